// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the main control state machine of a 16-bit multicycle RISC core that shares one memory port between instruction fetch and data access. Each instruction passes through a chain of single-cycle states. In every state the block drives the select and enable lines of the datapath: PC update, memory address source, memory read and write, instruction-register load, register write and its data source, the two ALU operand selects, the ALU operation and the conditional PC write. The datapath, the register file and the memory sit outside the block.

The instruction fields arrive on `op_in`, `ext_in` and `rd_in`. The block captures them on the clock edge that ends the decode cycle, so the datapath only has to present them during decode. When the extension bit is set, an extra cycle reads the word that follows the instruction into the memory data register. That word then acts as the immediate or displacement. Every instruction ends in an interrupt-check cycle. In that cycle a pending request, while interrupts are enabled, saves the PC into a dedicated return register, disables interrupts and redirects the PC to the service routine. A return instruction restores the PC from that register and enables interrupts again.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low the block is held in the fetch cycle with `int_en` = 0. The first cycle after reset is a fetch.
- R2: The fetch cycle drives these outputs: `mem_rd`=1, `addr_sel`=0 (address from PC), `alu_a`=2'b10 (PC), `alu_b`=2'b10 (constant 2), `alu_op`=3'b000 (add), `pc_wr`=1, `pc_src`=2'b00 (ALU result). The next cycle is decode, with `ir_wr`=1 and every other output 0.
- R3: With `ext_in`=1 in decode, the following cycle is a fetch-immediate. It drives the same outputs as fetch and then continues into the instruction's own states. In those states an extended operand is taken from the memory data register (`alu_b`=2'b01).
- R4: The ALU opcodes and their `alu_op` values are: add 0000001→000, sub 0000010→001, and 0001001→010, or 0000101→011, nor 0000110→100, mult 0000011→110, div 0000100→111. An ALU opcode takes an execute cycle (`alu_a`=2'b00, `alu_b`=2'b00 or 2'b01 if extended) and then a write-back cycle with `mem_to_reg`=0.
- R5: Write-back for an ALU result or a load asserts `reg_wr` only when the destination field `rd_in` is not 0.
- R6: Load (0011111) runs three cycles. First, an address cycle: add, `alu_a`=2'b00, `alu_b`=2'b11 (instruction bits [8:0]) or 2'b01 if extended. Second, a read with `addr_sel`=1 and `mem_rd`=1. Third, a write-back with `mem_to_reg`=1.
- R7: Store (0010000) runs the same address cycle as load, then one cycle with `addr_sel`=1 and `mem_wr`=1, and writes no register.
- R8: Compare (1111111) takes one cycle. It runs a subtract on A and B with `flag_wr`=1 and `reg_wr`=0.
- R9: Branches 1110000 (z=1), 1110001 (z=0), 1110010 (l=1) and 1110011 (l=0 and z=0) take one cycle with `pc_cond`=1, `alu_a`=2'b10, `alu_b`=2'b11 and add. `pc_wr` is 1 exactly when the condition holds.
- R10: Jump-to-register (010xxxx) takes one cycle: `pc_wr`=1, `pc_src`=2'b00, A+B. Jump (100xxxx) takes one cycle: `pc_wr`=1, `pc_src`=2'b01 (memory data register). Jump-and-link (011xxxx) first runs a cycle with `reg_wr`=1 and `link_wr`=1 (PC into r15), then the jump cycle.
- R11: The interrupt-check cycle follows every instruction. If `irq`=1 and `int_en`=1, it drives `pc_wr`=1, `pc_src`=2'b10 (vector 0x0004) and `irq_save`=1, and `int_en` clears. Otherwise all outputs are 0. Fetch comes next in both cases.
- R12: Return (0010010) takes one cycle with `pc_wr`=1 and `pc_src`=2'b11 (interrupt return register), and sets `int_en`.
- R13: No-operation (0000000) and every unassigned opcode go straight to interrupt check, after the fetch-immediate cycle if extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_in | input | 7 | Opcode field, sampled at the end of decode |
| ext_in | input | 1 | Extension bit, sampled at the end of decode |
| rd_in | input | 4 | Destination register field, sampled at the end of decode |
| flag_z | input | 1 | Zero flag from the status register |
| flag_l | input | 1 | Less-than flag from the status register |
| irq | input | 1 | Interrupt request |
| pc_wr | output | 1 | PC write enable |
| pc_cond | output | 1 | Marks a conditional PC write |
| pc_src | output | 2 | PC source: ALU, MDR, vector, return register |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| mem_to_reg | output | 1 | Write data from MDR instead of ALU |
| link_wr | output | 1 | Write PC into r15 |
| flag_wr | output | 1 | Status flag update |
| irq_save | output | 1 | Load PC into interrupt return register |
| alu_a | output | 2 | First ALU operand select |
| alu_b | output | 2 | Second ALU operand select |
| alu_op | output | 3 | ALU operation |
| int_en | output | 1 | Interrupt enable |

## Verification
The assertions assume that the fields on `op_in`, `ext_in` and `rd_in` are valid during decode. They also assume that `flag_z`, `flag_l` and `irq` stay steady through any cycle whose outputs depend on them. The bench meets both conditions: it changes these inputs only on the falling edge at the start of a fetch cycle and holds them for the whole instruction. It sweeps all 128 opcodes with both extension values, all four flag combinations and both request levels. Interrupts are enabled only through the return opcode.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] op_in,
  input  logic       ext_in,
  input  logic [3:0] rd_in,
  input  logic       flag_z,
  input  logic       flag_l,
  input  logic       irq,
  output logic       pc_wr,
  output logic       pc_cond,
  output logic [1:0] pc_src,
  output logic       addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_wr,
  output logic       reg_wr,
  output logic       mem_to_reg,
  output logic       link_wr,
  output logic       flag_wr,
  output logic       irq_save,
  output logic [1:0] alu_a,
  output logic [1:0] alu_b,
  output logic [2:0] alu_op,
  output logic       int_en
);

  typedef enum logic [3:0] {
    S_FETCH, S_DEC, S_FIMM, S_EXEC, S_WBA, S_EA, S_MRD, S_WBM,
    S_MWR, S_CMP, S_BR, S_JREG, S_LINK, S_JMP, S_RETI, S_ICHK
  } st_t;

  localparam logic [6:0] OP_NOP  = 7'b0000000;
  localparam logic [6:0] OP_LD   = 7'b0011111;
  localparam logic [6:0] OP_ST   = 7'b0010000;
  localparam logic [6:0] OP_CMP  = 7'b1111111;
  localparam logic [6:0] OP_RETI = 7'b0010010;

  st_t        st, st_nx;
  logic [6:0] op_q;
  logic       ext_q;
  logic [3:0] rd_q;
  logic       ie;
  logic       take;
  logic       irq_go;

  function automatic logic alu_class(input logic [6:0] o);
    return (o >= 7'd1 && o <= 7'd6) || o == 7'd9;
  endfunction

  function automatic logic [2:0] alu_code(input logic [6:0] o);
    case (o)
      7'd1:    return 3'b000;
      7'd2:    return 3'b001;
      7'd9:    return 3'b010;
      7'd5:    return 3'b011;
      7'd6:    return 3'b100;
      7'd3:    return 3'b110;
      7'd4:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic st_t route(input logic [6:0] o);
    if (alu_class(o))                 return S_EXEC;
    else if (o == OP_LD || o == OP_ST) return S_EA;
    else if (o == OP_CMP)             return S_CMP;
    else if (o[6:2] == 5'b11100)      return S_BR;
    else if (o[6:4] == 3'b010)        return S_JREG;
    else if (o[6:4] == 3'b011)        return S_LINK;
    else if (o[6:4] == 3'b100)        return S_JMP;
    else if (o == OP_RETI)            return S_RETI;
    else                              return S_ICHK;
  endfunction

  always_comb begin
    case (op_q[1:0])
      2'd0:    take = flag_z;
      2'd1:    take = !flag_z;
      2'd2:    take = flag_l;
      default: take = !flag_l && !flag_z;
    endcase
  end

  assign irq_go = irq && ie;
  assign int_en = ie;

  always_comb begin
    st_nx = S_ICHK;
    case (st)
      S_FETCH: st_nx = S_DEC;
      S_DEC:   st_nx = ext_in ? S_FIMM : (op_in == OP_NOP ? S_ICHK : route(op_in));
      S_FIMM:  st_nx = route(op_q);
      S_EXEC:  st_nx = S_WBA;
      S_EA:    st_nx = (op_q == OP_LD) ? S_MRD : S_MWR;
      S_MRD:   st_nx = S_WBM;
      S_LINK:  st_nx = S_JMP;
      S_ICHK:  st_nx = S_FETCH;
      default: st_nx = S_ICHK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_FETCH;
      op_q  <= '0;
      ext_q <= 1'b0;
      rd_q  <= '0;
      ie    <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_DEC) begin
        op_q  <= op_in;
        ext_q <= ext_in;
        rd_q  <= rd_in;
      end
      if (st == S_RETI) ie <= 1'b1;
      else if (st == S_ICHK && irq_go) ie <= 1'b0;
    end
  end

  always_comb begin
    pc_wr = 0; pc_cond = 0; pc_src = 2'b00; addr_sel = 0;
    mem_rd = 0; mem_wr = 0; ir_wr = 0; reg_wr = 0; mem_to_reg = 0;
    link_wr = 0; flag_wr = 0; irq_save = 0;
    alu_a = 2'b00; alu_b = 2'b00; alu_op = 3'b000;
    case (st)
      S_FETCH, S_FIMM: begin
        mem_rd = 1; pc_wr = 1; alu_a = 2'b10; alu_b = 2'b10;
      end
      S_DEC:  ir_wr = 1;
      S_EXEC: begin
        alu_b  = ext_q ? 2'b01 : 2'b00;
        alu_op = alu_code(op_q);
      end
      S_WBA:  reg_wr = (rd_q != 4'd0);
      S_EA:   alu_b = ext_q ? 2'b01 : 2'b11;
      S_MRD:  begin addr_sel = 1; mem_rd = 1; end
      S_WBM:  begin reg_wr = (rd_q != 4'd0); mem_to_reg = 1; end
      S_MWR:  begin addr_sel = 1; mem_wr = 1; end
      S_CMP:  begin alu_op = 3'b001; flag_wr = 1; end
      S_BR:   begin
        pc_cond = 1; pc_wr = take; alu_a = 2'b10; alu_b = 2'b11;
      end
      S_JREG: pc_wr = 1;
      S_LINK: begin reg_wr = 1; link_wr = 1; end
      S_JMP:  begin pc_wr = 1; pc_src = 2'b01; end
      S_RETI: begin pc_wr = 1; pc_src = 2'b11; end
      S_ICHK: begin
        pc_wr = irq_go; irq_save = irq_go;
        pc_src = irq_go ? 2'b10 : 2'b00;
      end
      default: ;
    endcase
  end

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R7
  AST_DECODE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |-> $past(mem_rd && !addr_sel && pc_wr)); // R2
  AST_SAVE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_save |-> (int_en && irq && pc_src == 2'b10)); // R11
  AST_SAVE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_save |=> !int_en); // R11
  AST_RETURN_SETS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'b11) |=> int_en); // R12
  AST_COND_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    pc_cond |-> (alu_a == 2'b10 && alu_b == 2'b11 && !reg_wr)); // R9
  AST_LINK_THEN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    link_wr |=> (pc_wr && pc_src == 2'b01)); // R10
  AST_MDR_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_to_reg |-> $past(mem_rd && addr_sel)); // R6

endmodule

// File: tb/sim_mc_ctrl_fsm.sv
module sim_mc_ctrl_fsm;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [6:0] op_in = 0;
  logic ext_in = 0, flag_z = 0, flag_l = 0, irq = 0;
  logic [3:0] rd_in = 0;
  logic pc_wr, pc_cond, addr_sel, mem_rd, mem_wr, ir_wr, reg_wr, mem_to_reg;
  logic link_wr, flag_wr, irq_save, int_en;
  logic [1:0] pc_src, alu_a, alu_b;
  logic [2:0] alu_op;

  mc_ctrl_fsm u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic ie_m = 0;

  wire [19:0] ov = {pc_wr, pc_cond, pc_src, addr_sel, mem_rd, mem_wr, ir_wr,
                    reg_wr, mem_to_reg, link_wr, flag_wr, irq_save, alu_a, alu_b, alu_op};

  function automatic logic [19:0] mk(input logic pw, pc, input logic [1:0] ps,
      input logic ad, mr, mw, ir, rw, m2r, lk, fw, sv,
      input logic [1:0] a, b, input logic [2:0] op);
    return {pw, pc, ps, ad, mr, mw, ir, rw, m2r, lk, fw, sv, a, b, op};
  endfunction

  localparam logic [19:0] V_FETCH = {1'b1,1'b0,2'b00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,2'b10,3'b000};
  localparam logic [19:0] V_DEC   = {7'b0000000,1'b1,12'b0};

  function automatic int alu_map(input logic [6:0] o);
    case (o)
      7'd1: return 0; 7'd2: return 1; 7'd9: return 2; 7'd5: return 3;
      7'd6: return 4; 7'd3: return 6; 7'd4: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input logic [19:0] got, exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: outputs got=%05h exp=%05h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [6:0] o, input logic e, input logic [3:0] rd,
                     input logic z, l, rq);
    logic [19:0] ex[8];
    string tg[8];
    int n = 0;
    logic take;
    ex[n] = V_FETCH; tg[n] = "R2"; n++;
    ex[n] = V_DEC;   tg[n] = "R2"; n++;
    op_in = o; ext_in = e; rd_in = rd; flag_z = z; flag_l = l; irq = rq;
    if (e) begin ex[n] = V_FETCH; tg[n] = "R3"; n++; end
    if (alu_map(o) >= 0) begin
      ex[n] = mk(0,0,0,0,0,0,0,0,0,0,0,0,2'b00,e ? 2'b01 : 2'b00,3'(alu_map(o))); tg[n] = "R4"; n++;
      ex[n] = mk(0,0,0,0,0,0,0,rd != 0,0,0,0,0,0,0,0); tg[n] = "R5"; n++;
    end else if (o == 7'b0011111 || o == 7'b0010000) begin
      ex[n] = mk(0,0,0,0,0,0,0,0,0,0,0,0,2'b00,e ? 2'b01 : 2'b11,0); tg[n] = "R6"; n++;
      if (o == 7'b0011111) begin
        ex[n] = mk(0,0,0,1,1,0,0,0,0,0,0,0,0,0,0); tg[n] = "R6"; n++;
        ex[n] = mk(0,0,0,0,0,0,0,rd != 0,1,0,0,0,0,0,0); tg[n] = "R5"; n++;
      end else begin
        ex[n] = mk(0,0,0,1,0,1,0,0,0,0,0,0,0,0,0); tg[n] = "R7"; n++;
      end
    end else if (o == 7'b1111111) begin
      ex[n] = mk(0,0,0,0,0,0,0,0,0,0,1,0,0,0,3'b001); tg[n] = "R8"; n++;
    end else if (o[6:2] == 5'b11100) begin
      case (o[1:0])
        2'd0: take = z;
        2'd1: take = !z;
        2'd2: take = l;
        default: take = !l && !z;
      endcase
      ex[n] = mk(take,1,0,0,0,0,0,0,0,0,0,0,2'b10,2'b11,0); tg[n] = "R9"; n++;
    end else if (o[6:4] == 3'b010) begin
      ex[n] = mk(1,0,0,0,0,0,0,0,0,0,0,0,0,0,0); tg[n] = "R10"; n++;
    end else if (o[6:4] == 3'b011 || o[6:4] == 3'b100) begin
      if (o[6:4] == 3'b011) begin
        ex[n] = mk(0,0,0,0,0,0,0,1,0,1,0,0,0,0,0); tg[n] = "R10"; n++;
      end
      ex[n] = mk(1,0,2'b01,0,0,0,0,0,0,0,0,0,0,0,0); tg[n] = "R10"; n++;
    end else if (o == 7'b0010010) begin
      ex[n] = mk(1,0,2'b11,0,0,0,0,0,0,0,0,0,0,0,0); tg[n] = "R12"; n++;
      ie_m = 1;
    end
    if (rq && ie_m) begin
      ex[n] = mk(1,0,2'b10,0,0,0,0,0,0,0,0,1,0,0,0); ie_m = 0;
    end else ex[n] = '0;
    tg[n] = (n == 2 || (n == 3 && e)) ? "R13" : "R11"; n++;
    for (int i = 0; i < n; i++) begin
      #1 chk(ov, ex[i], tg[i]);
      @(negedge clk);
    end
    #1 total++;
    if (int_en !== ie_m) begin
      bad++;
      $display("FAIL R11/R12 int_en: got=%b exp=%b", int_en, ie_m);
    end
  endtask

  initial begin
    #(PERIOD*190000);
    bad++;
    $display("FAIL watchdog: got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(ov, V_FETCH, "R1");
    total++;
    if (int_en !== 1'b0) begin bad++; $display("FAIL R1 int_en: got=%b exp=0", int_en); end
    rst_n = 1;
    @(negedge clk);
    #1 chk(ov, V_DEC, "R1");
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    // R11: request with interrupts disabled is ignored
    run(7'b0000000, 0, 4'd0, 0, 0, 1);
    // R12 then R11: return enables, a pending request is then taken
    run(7'b0010010, 0, 4'd0, 0, 0, 0);
    run(7'b0000001, 0, 4'd3, 0, 0, 1);
    // R5: write to r0 suppressed for ALU and load
    run(7'b0000010, 0, 4'd0, 0, 0, 0);
    run(7'b0011111, 1, 4'd0, 0, 0, 0);
    for (int q = 0; q < 2; q++)
      for (int o = 0; o < 128; o++)
        for (int e = 0; e < 2; e++)
          for (int f = 0; f < 4; f++)
            run(7'(o), e[0], 4'(o + f + e), f[1], f[0], q[0] ^ f[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule